// File: doc/BRIEF.md
# Bidirectional Recirculating Shift Register

This block is a 32-stage serial shift register that moves its contents one stage per clock edge, in a direction picked by a single control line. Each direction has its own serial input, which feeds the stage at the entry end, and its own serial output, which is the stage at the exit end. A rotate control takes the bit leaving the exit end and puts it back in at the entry end, so the stored word circulates instead of taking new data. A freeze control stops all movement.

All stages are also brought out as a parallel read-only bus so the surrounding logic can observe the word. The design runs on one clock. A synchronous active-high reset clears every stage, and it wins over every other control.

Top module: `bidir_rotshift`

## Requirements
- R1: When `rst` is high at a rising clock edge, all 32 stages become 0 after that edge, even if `freeze` is high.
- R2: When `rst` is low and `freeze` is high at an edge, every stage keeps its value and the serial inputs, direction and rotate controls have no effect.
- R3: With `rst` and `freeze` low and `go_left` = 0 (right shift), stage i takes the old value of stage i+1 for i = 0..30.
- R4: In right shift with `rotate` = 0, stage 31 takes `ser_in_r`.
- R5: With `rst` and `freeze` low and `go_left` = 1 (left shift), stage i takes the old value of stage i-1 for i = 1..31.
- R6: In left shift with `rotate` = 0, stage 0 takes `ser_in_l`.
- R7: With `rotate` = 1, a right shift loads stage 31 from the old stage 0, and a left shift loads stage 0 from the old stage 31. Both serial inputs are ignored.
- R8: `ser_out_r` always equals stage 0 and `ser_out_l` always equals stage 31, with no added register delay.
- R9: The serial input that belongs to the direction not selected has no effect on the stages.
- R10: After 32 rotating shifts in one direction, the stages hold the word they held before the shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of all stages |
| freeze | input | 1 | Holds all stages when high |
| go_left | input | 1 | 1 selects left shift (toward stage 31), 0 selects right shift (toward stage 0) |
| rotate | input | 1 | 1 feeds the exiting end stage back into the entry end |
| ser_in_r | input | 1 | Serial input for right shift, enters stage 31 |
| ser_in_l | input | 1 | Serial input for left shift, enters stage 0 |
| ser_out_r | output | 1 | Serial output for right shift, stage 0 |
| ser_out_l | output | 1 | Serial output for left shift, stage 31 |
| stages | output | 32 | Parallel view of all stages, bit i is stage i |

## Verification
The hardest case to reach from the ports is rotation of a non-trivial word. The register only takes data one bit per cycle, so the stimulus first loads a mixed 32-bit pattern serially over 32 right shifts. It then rotates a full lap in each direction while driving the ignored serial inputs against the data. A reset is applied while `freeze` is high to show that the clear wins over the freeze.

// File: rtl/brs_pkg.sv
package brs_pkg;

    localparam int unsigned STAGES = 32;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_HOLD  = 2'd1,
        OP_SHR   = 2'd2,
        OP_SHL   = 2'd3
    } op_e;

    typedef struct packed {
        op_e  op;
        logic fill;
    } step_t;

    // Select the bit that enters the vacated end stage.
    function automatic logic entry_bit(
        input logic left,
        input logic rot,
        input logic sin_r,
        input logic sin_l,
        input logic lo_end,
        input logic hi_end
    );
        if (rot)
            return left ? hi_end : lo_end;
        return left ? sin_l : sin_r;
    endfunction

endpackage

// File: rtl/brs_mode_decode.sv
module brs_mode_decode
    import brs_pkg::*;
(
    input  logic  rst,
    input  logic  freeze,
    input  logic  go_left,
    input  logic  rotate,
    input  logic  ser_in_r,
    input  logic  ser_in_l,
    input  logic  lo_end,
    input  logic  hi_end,
    output step_t step
);

    always_comb begin
        step.fill = entry_bit(go_left, rotate, ser_in_r, ser_in_l, lo_end, hi_end);
        if (rst)
            step.op = OP_CLEAR;
        else if (freeze)
            step.op = OP_HOLD;
        else if (go_left)
            step.op = OP_SHL;
        else
            step.op = OP_SHR;
    end

endmodule

// File: rtl/brs_stage_mux.sv
module brs_stage_mux
    import brs_pkg::*;
#(
    parameter int unsigned N = STAGES
) (
    input  step_t        step,
    input  logic [N-1:0] q,
    output logic [N-1:0] d
);

    for (genvar i = 0; i < N; i++) begin : g_stage
        logic from_lower;
        logic from_upper;

        if (i == 0) begin : g_lo
            assign from_lower = step.fill;
        end else begin : g_lo_mid
            assign from_lower = q[i-1];
        end

        if (i == N - 1) begin : g_hi
            assign from_upper = step.fill;
        end else begin : g_hi_mid
            assign from_upper = q[i+1];
        end

        always_comb begin
            unique case (step.op)
                OP_CLEAR: d[i] = 1'b0;
                OP_HOLD:  d[i] = q[i];
                OP_SHR:   d[i] = from_upper;
                OP_SHL:   d[i] = from_lower;
                default:  d[i] = q[i];
            endcase
        end
    end

endmodule

// File: rtl/brs_store.sv
module brs_store #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    always_ff @(posedge clk) begin
        q <= d;
    end

endmodule

// File: rtl/bidir_rotshift.sv
module bidir_rotshift
    import brs_pkg::*;
#(
    parameter int unsigned N = STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         freeze,
    input  logic         go_left,
    input  logic         rotate,
    input  logic         ser_in_r,
    input  logic         ser_in_l,
    output logic         ser_out_r,
    output logic         ser_out_l,
    output logic [N-1:0] stages
);

    localparam int unsigned TOP = N - 1;

    step_t        step;
    logic [N-1:0] q;
    logic [N-1:0] d;

    brs_mode_decode u_decode (
        .rst      (rst),
        .freeze   (freeze),
        .go_left  (go_left),
        .rotate   (rotate),
        .ser_in_r (ser_in_r),
        .ser_in_l (ser_in_l),
        .lo_end   (q[0]),
        .hi_end   (q[TOP]),
        .step     (step)
    );

    brs_stage_mux #(.N(N)) u_mux (
        .step (step),
        .q    (q),
        .d    (d)
    );

    brs_store #(.N(N)) u_store (
        .clk (clk),
        .d   (d),
        .q   (q)
    );

    assign stages    = q;
    assign ser_out_r = q[0];
    assign ser_out_l = q[TOP];

endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
    parameter int unsigned N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         freeze,
    input logic         go_left,
    input logic         rotate,
    input logic         ser_in_r,
    input logic         ser_in_l,
    input logic         ser_out_r,
    input logic         ser_out_l,
    input logic [N-1:0] stages
);

    p_clear_r1: assert property (@(posedge clk)
        rst |=> stages == '0);

    p_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(stages));

    p_move_right_r3: assert property (@(posedge clk) disable iff (rst)
        (!freeze && !go_left) |=> stages[N-2:0] == $past(stages[N-1:1]));

    p_fill_right_r4: assert property (@(posedge clk) disable iff (rst)
        (!freeze && !go_left && !rotate) |=> stages[N-1] == $past(ser_in_r));

    p_move_left_r5: assert property (@(posedge clk) disable iff (rst)
        (!freeze && go_left) |=> stages[N-1:1] == $past(stages[N-2:0]));

    p_fill_left_r6: assert property (@(posedge clk) disable iff (rst)
        (!freeze && go_left && !rotate) |=> stages[0] == $past(ser_in_l));

    p_wrap_right_r7: assert property (@(posedge clk) disable iff (rst)
        (!freeze && !go_left && rotate) |=> stages[N-1] == $past(stages[0]));

    p_wrap_left_r7: assert property (@(posedge clk) disable iff (rst)
        (!freeze && go_left && rotate) |=> stages[0] == $past(stages[N-1]));

    p_ends_r8: assert property (@(posedge clk) disable iff (rst)
        ser_out_r == stages[0] && ser_out_l == stages[N-1]);

endmodule

bind bidir_rotshift brs_checker #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .freeze    (freeze),
    .go_left   (go_left),
    .rotate    (rotate),
    .ser_in_r  (ser_in_r),
    .ser_in_l  (ser_in_l),
    .ser_out_r (ser_out_r),
    .ser_out_l (ser_out_l),
    .stages    (stages)
);

// File: tb/bidir_rotshift_tb_top.sv
module bidir_rotshift_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         freeze = 1'b0;
    logic         go_left = 1'b0;
    logic         rotate = 1'b0;
    logic         ser_in_r = 1'b0;
    logic         ser_in_l = 1'b0;
    logic         ser_out_r;
    logic         ser_out_l;
    logic [N-1:0] stages;

    typedef struct {
        logic [N-1:0] word;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    logic [N-1:0] model = '0;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_rotshift #(.N(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .freeze    (freeze),
        .go_left   (go_left),
        .rotate    (rotate),
        .ser_in_r  (ser_in_r),
        .ser_in_l  (ser_in_l),
        .ser_out_r (ser_out_r),
        .ser_out_l (ser_out_l),
        .stages    (stages)
    );

    // Driver: apply one cycle of controls and push the expected result.
    task automatic step(input logic r, input logic f, input logic l,
                        input logic rot, input logic sr, input logic sl,
                        input string tag_in);
        exp_t  e;
        string tag;
        logic  fill;
        @(negedge clk);
        rst = r; freeze = f; go_left = l; rotate = rot;
        ser_in_r = sr; ser_in_l = sl;
        if (r) begin
            model = '0; tag = "R1";
        end else if (f) begin
            tag = "R2";
        end else if (!l) begin
            fill  = rot ? model[0] : sr;
            model = {fill, model[N-1:1]};
            tag   = rot ? "R7" : "R3/R4";
        end else begin
            fill  = rot ? model[N-1] : sl;
            model = {model[N-2:0], fill};
            tag   = rot ? "R7" : "R5/R6";
        end
        if (tag_in != "") tag = tag_in;
        e.word = model;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (stages !== e.word) begin
                n_fail++;
                $display("FAIL %s stages: actual %h expected %h", e.tag, stages, e.word);
            end
            n_checks++;
            if (ser_out_r !== e.word[0] || ser_out_l !== e.word[N-1]) begin
                n_fail++;
                $display("FAIL R8 serial outs: actual r=%b l=%b expected r=%b l=%b",
                         ser_out_r, ser_out_l, e.word[0], e.word[N-1]);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pat;
        logic [N-1:0] saved;
        pat = 32'hA5C3_1F07;

        // R1 reset state
        step(1, 0, 0, 0, 1, 1, "R1");
        step(1, 0, 0, 0, 1, 1, "R1");

        // R3 R4 serial load through right input; R9 left input toggled against it
        for (int i = 0; i < N; i++)
            step(0, 0, 0, 0, pat[i], ~pat[i], "R9");

        // R2 freeze with all other inputs toggling
        step(0, 1, 0, 0, 1, 1, "R2");
        step(0, 1, 1, 1, 0, 1, "R2");
        step(0, 1, 1, 0, 1, 0, "R2");

        // R10 full right rotation lap, serial inputs ignored
        saved = model;
        for (int i = 0; i < N; i++)
            step(0, 0, 0, 1, ~model[0], 1'b1, "R7");
        sb_q[$].tag = "R10";
        if (model !== saved) $display("bench model mismatch");

        // R5 R6 left shifting, R9 right input toggled
        for (int i = 0; i < 12; i++)
            step(0, 0, 1, 0, i[0], i[1] ^ i[2], "R5/R6");
        for (int i = 0; i < 6; i++)
            step(0, 0, 1, 0, ~i[0], 1'b0, "R9");

        // R10 full left rotation lap
        for (int i = 0; i < N; i++)
            step(0, 0, 1, 1, 1'b1, ~model[N-1], "R7");
        sb_q[$].tag = "R10";

        // alternating right and left plain shifts
        for (int i = 0; i < 8; i++)
            step(0, 0, i[0], 0, 1'b1, 1'b0, "");

        // R1 reset wins over freeze
        step(1, 1, 1, 1, 1, 1, "R1");
        step(0, 0, 0, 0, 1, 0, "R4");
        step(0, 0, 1, 0, 0, 1, "R6");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule